// File: doc/BRIEF.md
# Manchester tag frame decoder

This block turns a stream of half-bit symbols into tag identifiers. One symbol arrives in each cycle in which the valid input is high. Frames are separated by a delimiter that is not legal Manchester code: three ones followed by three zeros. Between two delimiters, each aligned pair of symbols carries one data bit. The decoded bits are shifted into an identifier register, MSB first.

An identifier is only known to be complete when the next delimiter shows up. At that point the block presents the accumulated value on a high/low output pair, together with a one-cycle valid pulse, unless the value is zero. The accumulator then restarts from zero. A pair that is not a legal Manchester pair drops frame lock. The frame being decoded is then abandoned without a report, and the decoder searches for the next delimiter.

Internally, symbols pass through a six-deep look-ahead window. The delimiter is tested on the whole window, and pairs are decoded from its oldest entry. Each bit is therefore decided five symbols after it arrives.

Top module: `manch_frame_dec`

## Requirements
- R1: After reset `id_valid_o` is 0 and `id_hi_o` and `id_lo_o` are all zero.
- R2: The delimiter is the symbol sequence 1,1,1,0,0,0 in arrival order. While unlocked, it is recognised starting at any symbol position, regardless of how many symbols came before it. Recognising it gives frame lock, and the following six symbols are skipped before pairing starts.
- R3: While locked, the symbol pair (1 then 0) decodes to data bit 0 and the pair (0 then 1) decodes to data bit 1.
- R4: Decoded bits shift into a 44-bit accumulator at bit 0, MSB first. The low 32 bits overflow into the 12-bit high part, and bits older than 44 are lost. The report puts accumulator bits 43:32 on `id_hi_o` and bits 31:0 on `id_lo_o`.
- R5: A delimiter that ends a locked frame with a non-zero accumulator raises `id_valid_o` for exactly one cycle. This is the cycle after the clock edge that accepts the delimiter's last symbol.
- R6: A delimiter that ends a frame whose accumulator is zero produces no pulse and leaves the outputs unchanged.
- R7: Every delimiter clears the accumulator, so the next identifier is built from zero.
- R8: While locked, an aligned pair 0,0 or 1,1 drops lock. The next delimiter then produces no report, but restores lock for the frame after it.
- R9: Cycles with `sym_valid_i` low have no effect, whatever `sym_i` holds.
- R10: `id_hi_o` and `id_lo_o` hold their value until the next report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sym_valid_i | input | 1 | Symbol strobe |
| sym_i | input | 1 | Half-bit symbol |
| id_valid_o | output | 1 | One-cycle report pulse |
| id_hi_o | output | 12 | Identifier bits 43:32 |
| id_lo_o | output | 32 | Identifier bits 31:0 |

## Verification
Every result of this block is due one clock edge after the symbol that completes the closing delimiter is accepted; the output register is the only stage on that path. The bench drives each symbol for a single cycle and samples one time unit after the edge that accepts it. Therefore the check that follows the final delimiter symbol must see the pulse, and one idle cycle later it must see the pulse gone. A negative-edge monitor counts every pulse, so that frames expected to stay silent are proven silent, and not merely missed by the sampling point.

// File: rtl/manch_frame_pkg.sv
package manch_frame_pkg;
   localparam int DELIM_LEN = 6;
   localparam logic [DELIM_LEN-1:0] DELIM_PAT = 6'b111000; // MSB = oldest symbol
   localparam int DEF_HI_W = 12;
   localparam int DEF_LO_W = 32;
endpackage

// File: rtl/mfd_window.sv
module mfd_window #(
   parameter int LEN = 6
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           push,
   input  logic           sym,
   output logic [LEN-1:0] view,      // window including the symbol being pushed
   output logic           view_full
);
   localparam int CW = $clog2(LEN);

   logic [LEN-2:0] hist_q;
   logic [CW-1:0]  fill_q;

   assign view      = {hist_q, sym};
   assign view_full = (fill_q == CW'(LEN - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q <= '0;
         fill_q <= '0;
      end else if (push) begin
         hist_q <= view[LEN-2:0];
         if (!view_full) fill_q <= fill_q + 1'b1;
      end
   end

   assert_fill_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fill_q <= CW'(LEN - 1));
endmodule

// File: rtl/mfd_framer.sv
module mfd_framer
   import manch_frame_pkg::*;
#(
   parameter int LEN = DELIM_LEN,
   parameter logic [LEN-1:0] PAT = DELIM_PAT
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           push,
   input  logic [LEN-1:0] view,
   input  logic           view_full,
   output logic           bit_en,
   output logic           bit_val,
   output logic           delim_hit,
   output logic           frame_end
);
   localparam int SW = $clog2(LEN);

   logic          lock_q, phase_q, first_q;
   logic [SW-1:0] skip_q;
   logic          head, pat_ok, may_check;

   assign head      = view[LEN-1];
   assign pat_ok    = view_full && (view == PAT);
   assign may_check = (!lock_q) || (!phase_q);

   always_comb begin
      delim_hit = 1'b0;
      frame_end = 1'b0;
      bit_en    = 1'b0;
      bit_val   = head;
      if (push && skip_q == '0) begin
         if (may_check && pat_ok) begin
            delim_hit = 1'b1;
            frame_end = lock_q;
         end else if (lock_q && phase_q && first_q != head) begin
            bit_en = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q  <= 1'b0;
         phase_q <= 1'b0;
         first_q <= 1'b0;
         skip_q  <= '0;
      end else if (push) begin
         if (skip_q != '0) begin
            skip_q <= skip_q - 1'b1;
         end else if (delim_hit) begin
            lock_q  <= 1'b1;
            phase_q <= 1'b0;
            skip_q  <= SW'(LEN - 1);
         end else if (lock_q) begin
            if (!phase_q) begin
               first_q <= head;
               phase_q <= 1'b1;
            end else begin
               phase_q <= 1'b0;
               if (first_q == head) lock_q <= 1'b0;
            end
         end
      end
   end

   assert_skip_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (skip_q != '0) |-> lock_q);
   assert_end_needs_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |-> lock_q);
   assert_delim_locks_R2: assert property (@(posedge clk) disable iff (!rst_n)
      delim_hit |=> (lock_q && skip_q != '0));
endmodule

// File: rtl/mfd_accum.sv
module mfd_accum #(
   parameter int W = 44
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         bit_en,
   input  logic         bit_val,
   output logic [W-1:0] acc
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      acc <= '0;
      else if (clear)  acc <= '0;
      else if (bit_en) acc <= {acc[W-2:0], bit_val};
   end

   assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (acc == '0));
   assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && !bit_en) |=> $stable(acc));
endmodule

// File: rtl/manch_frame_dec.sv
module manch_frame_dec
   import manch_frame_pkg::*;
#(
   parameter int HI_W = DEF_HI_W,
   parameter int LO_W = DEF_LO_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            sym_valid_i,
   input  logic            sym_i,
   output logic            id_valid_o,
   output logic [HI_W-1:0] id_hi_o,
   output logic [LO_W-1:0] id_lo_o
);
   localparam int ID_W = HI_W + LO_W;

   if (HI_W < 1 || LO_W < 1) begin : g_bad_width
      $error("manch_frame_dec: field widths must be positive");
   end
   if (DELIM_LEN < 2) begin : g_bad_delim
      $error("manch_frame_dec: delimiter too short");
   end

   logic [DELIM_LEN-1:0] view;
   logic                 view_full, bit_en, bit_val, delim_hit, frame_end;
   logic [ID_W-1:0]      acc;

   mfd_window #(.LEN(DELIM_LEN)) u_win (
      .clk(clk), .rst_n(rst_n), .push(sym_valid_i), .sym(sym_i),
      .view(view), .view_full(view_full));

   mfd_framer #(.LEN(DELIM_LEN), .PAT(DELIM_PAT)) u_frm (
      .clk(clk), .rst_n(rst_n), .push(sym_valid_i), .view(view),
      .view_full(view_full), .bit_en(bit_en), .bit_val(bit_val),
      .delim_hit(delim_hit), .frame_end(frame_end));

   mfd_accum #(.W(ID_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .clear(delim_hit), .bit_en(bit_en),
      .bit_val(bit_val), .acc(acc));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         id_valid_o <= 1'b0;
         id_hi_o    <= '0;
         id_lo_o    <= '0;
      end else begin
         id_valid_o <= frame_end && (acc != '0);
         if (frame_end && acc != '0) begin
            id_hi_o <= acc[ID_W-1:LO_W];
            id_lo_o <= acc[LO_W-1:0];
         end
      end
   end

   assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      id_valid_o |=> !id_valid_o);
   assert_nonzero_report_R6: assert property (@(posedge clk) disable iff (!rst_n)
      id_valid_o |-> ({id_hi_o, id_lo_o} != '0));
   assert_hold_between_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !id_valid_o |-> ($stable(id_hi_o) && $stable(id_lo_o)));
endmodule

// File: tb/manch_frame_dec_tb.sv
module manch_frame_dec_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sym_valid = 1'b0;
   logic        sym = 1'b0;
   logic        id_valid;
   logic [11:0] id_hi;
   logic [31:0] id_lo;

   int checks = 0, fails = 0, pulses = 0;

   always #2 clk = ~clk;

   manch_frame_dec u_dut (
      .clk(clk), .rst_n(rst_n), .sym_valid_i(sym_valid), .sym_i(sym),
      .id_valid_o(id_valid), .id_hi_o(id_hi), .id_lo_o(id_lo));

   always @(negedge clk) if (rst_n && id_valid) pulses++;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic send(input logic b);
      sym = b; sym_valid = 1'b1;
      @(posedge clk); #1;
      sym_valid = 1'b0;
   endtask

   task automatic send_delim();
      send(1); send(1); send(1); send(0); send(0); send(0);
   endtask

   task automatic send_bit(input logic b);
      if (b) begin send(0); send(1); end
      else   begin send(1); send(0); end
   endtask

   task automatic send_bits(input logic [63:0] v, input int n);
      for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
   endtask

   // called right after the closing delimiter's last symbol
   task automatic expect_report(input logic [43:0] exp, input string tag);
      int p0;
      chk(id_valid === 1'b1, {tag, " pulse"}, 64'(id_valid), 64'd1);
      chk(id_hi === exp[43:32], {tag, " hi"}, 64'(id_hi), 64'(exp[43:32]));
      chk(id_lo === exp[31:0], {tag, " lo"}, 64'(id_lo), 64'(exp[31:0]));
      p0 = pulses;
      @(posedge clk); #1;
      chk(id_valid === 1'b0, {tag, " R5 one-cycle"}, 64'(id_valid), 64'd0);
      chk(pulses == p0 + 1, {tag, " R5 pulse count"}, 64'(pulses), 64'(p0 + 1));
   endtask

   task automatic expect_silent(input int p0, input logic [43:0] held, input string tag);
      @(posedge clk); #1;
      chk(pulses == p0, {tag, " no pulse"}, 64'(pulses), 64'(p0));
      chk({id_hi, id_lo} === held, {tag, " R10 held"}, 64'({id_hi, id_lo}), 64'(held));
   endtask

   task automatic t_reset();
      chk(id_valid === 1'b0, "R1 valid", 64'(id_valid), 64'd0);
      chk({id_hi, id_lo} === 44'd0, "R1 id", 64'({id_hi, id_lo}), 64'd0);
   endtask

   task automatic t_unaligned_first();   // R2 R3 R4 R5
      send(0); send(1); send(0);
      send_delim();
      send_bits(64'hABC_1234_5678, 44);
      send_delim();
      expect_report(44'hABC_1234_5678, "R2/R4 unaligned first frame");
   endtask

   task automatic t_back_to_back();      // R7 R3
      send_bits(64'h5A5, 12);
      send_delim();
      expect_report(44'h5A5, "R7 cleared short frame");
   endtask

   task automatic t_overflow();          // R4
      send_bits(64'hF00D_CAFE_BEEF, 48);
      send_delim();
      expect_report(44'h00D_CAFE_BEEF, "R4 overflow keeps 44");
   endtask

   task automatic t_zero();              // R6
      int p0 = pulses;
      logic [43:0] held = {id_hi, id_lo};
      send_bits(64'h0, 20);
      send_delim();
      chk(id_valid === 1'b0, "R6 zero frame", 64'(id_valid), 64'd0);
      expect_silent(p0, held, "R6");
   endtask

   task automatic t_invalid_pair();      // R8
      int p0 = pulses;
      logic [43:0] held = {id_hi, id_lo};
      send_bits(64'h3, 2);
      send(1); send(1);
      send_bits(64'h2, 2);
      send_delim();
      chk(id_valid === 1'b0, "R8 dropped frame", 64'(id_valid), 64'd0);
      expect_silent(p0, held, "R8");
      send_bits(64'h9, 4);
      send_delim();
      expect_report(44'h9, "R8 relock");
   endtask

   task automatic t_gaps();              // R9
      send_bits(64'h6, 3);
      sym = 1'b1;
      repeat (5) @(posedge clk);
      #1;
      send_bit(1);
      sym = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      send_bit(1);
      send_delim();
      expect_report(44'h1B, "R9 gaps ignored");
   endtask

   initial begin
      #(4 * 200000);
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      rst_n = 1'b1;
      @(posedge clk); #1;
      t_reset();
      t_unaligned_first();
      t_back_to_back();
      t_overflow();
      t_zero();
      t_invalid_pair();
      t_gaps();
      repeat (4) @(posedge clk);
      #1;
      chk(pulses == 5, "R5 total pulses", 64'(pulses), 64'd5);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule